// File: doc/BRIEF.md
# SPI Serial Memory Slave Front-End

This block is the serial side of a small SPI memory. It always acts as a slave. It watches chip select, the serial clock, the serial data input and a pause input. It collects an 8-bit instruction and decodes it. It then either collects a two-byte address followed by write bytes, or returns bytes from the memory back end on a serial output with an enable, so that the pad can be tri-stated. Decoded instructions, the current address and each received data byte go to the back end as single-cycle strobes. Read bytes come back on a parallel input after each read request.

All pins are sampled by the fabric clock through a short synchronizer, and the clock edges are detected from the samples. Data is taken in on the rising SCK edge and driven out on the falling SCK edge, which is SPI mode 0. Pulling the pause input low while SCK is low freezes the transfer where it stands. An unknown instruction shuts the port until chip select is raised and lowered again.

Top module: `spi_mem_front`

## Requirements
- R1: After reset, so_en is 0 and op_valid, wr_valid, rd_req and xfer_end are all 0.
- R2: The first byte after chip select falls is the instruction. It is valid only if bits 7..4 are zero. Bit 3 is ignored. Bits 2..0 select the instruction: 110 set write enable, 100 clear write enable, 101 read status, 001 write status, 011 read array, 010 write array. A valid instruction gives one op_valid pulse, with op_kind equal to bits 2..0.
- R3: Every byte arrives most significant bit first. Read array and write array are followed by a two-byte address, high byte first, and only its low ADDR_W bits are kept on mem_addr.
- R4: Each complete data byte of a write array gives one wr_valid pulse. The pulse carries the byte on wr_data and its address on mem_addr. The address then steps by one, wrapping modulo 2^ADDR_W.
- R5: Write status takes exactly one data byte, which is reported with a wr_valid pulse. Later bytes in the same selection produce no pulse.
- R6: In a read array, so_en rises once the first byte is loaded, on the falling SCK edge after the address. Bits leave MSB first, one per falling edge. Each loaded byte raises rd_req for the next address, so the read continues through incrementing addresses while chip select stays low. so_en stays 0 during the instruction and address bytes.
- R7: Read status raises rd_req and sends the returned status byte repeatedly, for as long as chip select stays low.
- R8: An instruction that is not valid produces no op_valid, wr_valid or xfer_end, and so_en stays 0 until chip select has gone high and then low again.
- R9: While chip select is high, SI and SCK are ignored and so_en is 0. Raising chip select drops any partly received byte. If a valid instruction was decoded, it also gives one xfer_end pulse.
- R10: hold_n is sampled only while SCK is low. While the port is held, SCK edges and SI are ignored, so_en is 0, and the bit position is kept, so the transfer resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for the SO pad |
| op_valid | output | 1 | Pulse: valid instruction decoded |
| op_kind | output | 3 | Instruction code (bits 2..0 of the opcode) |
| mem_addr | output | ADDR_W | Current array address |
| wr_valid | output | 1 | Pulse: a data byte was received |
| wr_data | output | 8 | Received data byte |
| rd_req | output | 1 | Pulse: back end must present the byte for mem_addr (or status) |
| rd_data | input | 8 | Byte from the back end, valid from the cycle after rd_req |
| xfer_end | output | 1 | Pulse: chip select rose after a valid instruction |

## Verification
A wrong bit counter or phase shows up at the ports within one byte. A byte offset by one bit reaches wr_data or the serial output, and a stuck phase produces either a missing strobe or an extra one, which the scoreboard then flags. A wrong address step shows up as the wrong mem_addr on the second byte of a burst, and across the wrap at the top of the array. Lockout and hold faults show up as a so_en level on the pad, or as strobes that appear while the port should be silent.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

  typedef enum logic [2:0] {
    OPK_WRSR  = 3'b001,
    OPK_WRITE = 3'b010,
    OPK_READ  = 3'b011,
    OPK_WRDI  = 3'b100,
    OPK_RDSR  = 3'b101,
    OPK_WREN  = 3'b110
  } op_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_OPC  = 3'd1,
    PH_ADDR = 3'd2,
    PH_WDAT = 3'd3,
    PH_RDAT = 3'd4,
    PH_SKIP = 3'd5,
    PH_LOCK = 3'd6
  } phase_e;

endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic sel,
  output logic held,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  // packed pin order: {cs_n, sck, si, hold_n}
  localparam logic [3:0] PIN_RST = 4'b1001;

  logic [3:0] stg [SYNC];
  logic       sck_p;

  for (genvar g = 0; g < SYNC; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= PIN_RST;
        else     stg[g] <= {cs_n, sck, si, hold_n};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= PIN_RST;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  logic cs_q, sck_q, hold_q;
  assign cs_q   = stg[SYNC-1][3];
  assign sck_q  = stg[SYNC-1][2];
  assign si_s   = stg[SYNC-1][1];
  assign hold_q = stg[SYNC-1][0];
  assign sel    = ~cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= 1'b0;
      held  <= 1'b0;
    end else begin
      sck_p <= sck_q;
      if (cs_q)        held <= 1'b0;
      else if (!sck_q) held <= ~hold_q;
    end
  end

  assign sck_rise = sel & ~held &  sck_q & ~sck_p;
  assign sck_fall = sel & ~held & ~sck_q &  sck_p;

endmodule

// File: rtl/spi_op_decode.sv
module spi_op_decode
  import spi_front_pkg::*;
(
  input  logic [7:0] code,
  output logic       valid,
  output op_kind_e   kind
);
  always_comb begin
    kind  = op_kind_e'(code[2:0]);
    valid = (code[7:4] == 4'd0) && (code[2:0] != 3'b000) && (code[2:0] != 3'b111);
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         so_bit
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      so_bit <= 1'b0;
    end else if (load) begin
      so_bit <= din[W-1];
      sh     <= {din[W-2:0], 1'b0};
    end else if (shift) begin
      so_bit <= sh[W-1];
      sh     <= {sh[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_front_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int ADDR_BYTES = 2,
  parameter int SYNC       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so_o,
  output logic              so_en,
  output logic              op_valid,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wr_valid,
  output logic [7:0]        wr_data,
  output logic              rd_req,
  input  logic [7:0]        rd_data,
  output logic              xfer_end
);
  localparam int ABC_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [ABC_W-1:0] ABC_LAST = ABC_W'(ADDR_BYTES - 1);

  logic sel, held, sck_rise, sck_fall, si_s;

  spi_pin_sampler #(.SYNC(SYNC)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sck      (sck),
    .si       (si),
    .hold_n   (hold_n),
    .sel      (sel),
    .held     (held),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .si_s     (si_s)
  );

  phase_e           phase;
  op_kind_e         kind;
  logic [2:0]       bitcnt;
  logic [6:0]       rx;
  logic [ABC_W-1:0] abytes;
  logic [ADDR_W-1:0] addr_r;
  logic             loaded;
  logic [7:0]       rx_byte;
  logic             byte_done;
  logic             dec_valid;
  op_kind_e         dec_kind;
  logic             tx_load, tx_shift;

  assign rx_byte   = {rx, si_s};
  assign byte_done = sck_rise && (bitcnt == 3'd7);
  assign tx_load   = sck_fall && (phase == PH_RDAT) && (bitcnt == 3'd0);
  assign tx_shift  = sck_fall && (phase == PH_RDAT) && (bitcnt != 3'd0);

  spi_op_decode u_dec (
    .code  (rx_byte),
    .valid (dec_valid),
    .kind  (dec_kind)
  );

  spi_tx_shift #(.W(8)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .load   (tx_load),
    .shift  (tx_shift),
    .din    (rd_data),
    .so_bit (so_o)
  );

  always_ff @(posedge clk) begin
    op_valid <= 1'b0;
    wr_valid <= 1'b0;
    rd_req   <= 1'b0;
    xfer_end <= 1'b0;
    if (rst) begin
      phase   <= PH_IDLE;
      kind    <= OPK_WREN;
      bitcnt  <= 3'd0;
      rx      <= '0;
      abytes  <= '0;
      addr_r  <= '0;
      loaded  <= 1'b0;
      wr_data <= '0;
    end else begin
      if (wr_valid && kind == OPK_WRITE) addr_r <= addr_r + 1'b1;

      if (!sel) begin
        if (phase == PH_ADDR || phase == PH_WDAT || phase == PH_RDAT || phase == PH_SKIP)
          xfer_end <= 1'b1;
        phase  <= PH_IDLE;
        bitcnt <= 3'd0;
        loaded <= 1'b0;
      end else if (phase == PH_IDLE) begin
        phase  <= PH_OPC;
        bitcnt <= 3'd0;
      end else if (sck_rise) begin
        bitcnt <= bitcnt + 3'd1;
        rx     <= rx_byte[6:0];
        if (byte_done) begin
          unique case (phase)
            PH_OPC: begin
              if (dec_valid) begin
                op_valid <= 1'b1;
                kind     <= dec_kind;
                abytes   <= '0;
                unique case (dec_kind)
                  OPK_WRITE, OPK_READ: phase <= PH_ADDR;
                  OPK_WRSR:            phase <= PH_WDAT;
                  OPK_RDSR: begin
                    phase  <= PH_RDAT;
                    rd_req <= 1'b1;
                  end
                  default:             phase <= PH_SKIP;
                endcase
              end else begin
                phase <= PH_LOCK;
              end
            end
            PH_ADDR: begin
              addr_r <= ADDR_W'({addr_r, rx_byte});
              if (abytes == ABC_LAST) begin
                if (kind == OPK_READ) begin
                  phase  <= PH_RDAT;
                  rd_req <= 1'b1;
                end else begin
                  phase  <= PH_WDAT;
                end
              end else begin
                abytes <= abytes + 1'b1;
              end
            end
            PH_WDAT: begin
              wr_valid <= 1'b1;
              wr_data  <= rx_byte;
              if (kind != OPK_WRITE) phase <= PH_SKIP;
            end
            default: ;
          endcase
        end
      end else if (tx_load) begin
        loaded <= 1'b1;
        rd_req <= 1'b1;
        if (kind == OPK_READ) addr_r <= addr_r + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) so_en <= 1'b0;
    else     so_en <= sel && !held && (phase == PH_RDAT) && loaded;
  end

  assign op_kind  = kind;
  assign mem_addr = addr_r;

endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk
  import spi_front_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              held,
  input logic [2:0]        phase,
  input logic              so_en,
  input logic              op_valid,
  input logic [2:0]        op_kind,
  input logic              wr_valid,
  input logic              rd_req,
  input logic              xfer_end,
  input logic [ADDR_W-1:0] mem_addr
);
  // R9
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !so_en);

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    held |=> !so_en);

  // R8
  lock_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOCK) |-> (!op_valid && !wr_valid && !so_en && !rd_req));

  // R2
  op_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (op_kind != 3'b000 && op_kind != 3'b111));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && op_kind == OPK_WRITE) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  // R6
  rd_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (phase == PH_RDAT));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op_valid, wr_valid, xfer_end}));
endmodule

bind spi_mem_front spi_mem_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel      (sel),
  .held     (held),
  .phase    (phase),
  .so_en    (so_en),
  .op_valid (op_valid),
  .op_kind  (op_kind),
  .wr_valid (wr_valid),
  .rd_req   (rd_req),
  .xfer_end (xfer_end),
  .mem_addr (mem_addr)
);

// File: tb/spi_mem_front_bench.sv
module spi_mem_front_bench;
  localparam int ADDR_W = 10;
  localparam int HALF   = 6;
  localparam logic [7:0] STATUS = 8'h8C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so_o, so_en, op_valid, wr_valid, rd_req, xfer_end;
  logic [2:0] op_kind;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;

  always #2 clk = ~clk;

  spi_mem_front #(.ADDR_W(ADDR_W), .ADDR_BYTES(2), .SYNC(2)) u_spi_mem_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so_o(so_o), .so_en(so_en), .op_valid(op_valid), .op_kind(op_kind),
    .mem_addr(mem_addr), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .xfer_end(xfer_end)
  );

  function automatic logic [7:0] mem_f(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ {a[9:8], 6'h15};
  endfunction

  // back-end model
  always @(posedge clk)
    if (rd_req) rd_data <= (op_kind == 3'd5) ? STATUS : mem_f(mem_addr);

  int checks = 0, fails = 0, xfer_cnt = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    bit         is_wr;
    bit         chk_addr;
    logic [9:0] a;
    logic [7:0] d;
    string      req;
  } ev_t;
  ev_t exp_q[$];

  task automatic push_op(input logic [2:0] k, input string req);
    ev_t e; e.is_wr = 0; e.chk_addr = 0; e.a = '0; e.d = {5'd0, k}; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic push_wr(input bit ca, input logic [9:0] a, input logic [7:0] d, input string req);
    ev_t e; e.is_wr = 1; e.chk_addr = ca; e.a = a; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (xfer_end) xfer_cnt++;
      if (op_valid || wr_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R8/R9 unexpected strobe", {op_valid, wr_valid}, 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          if (!e.is_wr)
            check(op_valid && op_kind == e.d[2:0], e.req, op_kind, e.d);
          else
            check(wr_valid && wr_data == e.d && (!e.chk_addr || mem_addr == e.a), e.req,
                  {mem_addr, wr_data}, {e.a, e.d});
        end
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit en_any, en_all;

  task automatic bits(input logic [7:0] b, input int hi, input int lo, inout logic [7:0] got);
    for (int i = hi; i >= lo; i--) begin
      si = b[i];
      wait_n(HALF);
      got[i] = so_o;
      en_any |= so_en;
      en_all &= so_en;
      sck = 1'b1;
      wait_n(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic byte_x(input logic [7:0] b, output logic [7:0] got);
    logic [7:0] g = '0;
    bits(b, 7, 0, g);
    got = g;
  endtask

  task automatic sel_on();  cs_n = 1'b0; wait_n(4); endtask
  task automatic sel_off(); wait_n(4); cs_n = 1'b1; wait_n(10); endtask

  task automatic clr_en(); en_any = 0; en_all = 1; endtask

  task automatic hold_pause();
    wait_n(HALF);
    hold_n = 1'b0;
    wait_n(HALF);
    check(so_en == 1'b0, "R10 so_en while held", so_en, 0);
    for (int k = 0; k < 3; k++) begin
      si = k[0];
      sck = 1'b1; wait_n(HALF);
      sck = 1'b0; wait_n(HALF);
    end
    hold_n = 1'b1;
    wait_n(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    int xc;
    wait_n(5);
    rst = 1'b0;
    wait_n(3);
    // R1 reset state
    check(so_en == 0 && op_valid == 0 && wr_valid == 0 && rd_req == 0 && xfer_end == 0,
          "R1 reset outputs", {so_en, op_valid, wr_valid, rd_req, xfer_end}, 0);

    // R2 simple instructions, bit 3 ignored
    push_op(3'b110, "R2 WREN");
    sel_on(); byte_x(8'h06, g); sel_off();
    push_op(3'b100, "R2 WRDI");
    sel_on(); byte_x(8'h04, g); sel_off();
    push_op(3'b110, "R2 bit3 don't-care");
    sel_on(); byte_x(8'h0E, g); sel_off();

    // R3 R4 write burst with xfer_end
    xc = xfer_cnt;
    push_op(3'b010, "R2 write op");
    push_wr(1, 10'h123, 8'h11, "R4 write byte 0");
    push_wr(1, 10'h124, 8'h22, "R4 write byte 1");
    sel_on(); byte_x(8'h02, g); byte_x(8'h01, g); byte_x(8'h23, g);
    byte_x(8'h11, g); byte_x(8'h22, g); sel_off();
    check(xfer_cnt == xc + 1, "R9 xfer_end after write", xfer_cnt - xc, 1);

    // R3 R4 address masking and wrap
    push_op(3'b010, "R2 write op bit3");
    push_wr(1, 10'h3FE, 8'hA1, "R3 masked address");
    push_wr(1, 10'h3FF, 8'hA2, "R4 top address");
    push_wr(1, 10'h000, 8'hA3, "R4 wrap to zero");
    sel_on(); byte_x(8'h0A, g); byte_x(8'hFF, g); byte_x(8'hFE, g);
    byte_x(8'hA1, g); byte_x(8'hA2, g); byte_x(8'hA3, g); sel_off();

    // R5 write status: one byte only
    push_op(3'b001, "R2 WRSR op");
    push_wr(0, 10'h0, 8'h8C, "R5 status byte");
    sel_on(); byte_x(8'h01, g); byte_x(8'h8C, g); byte_x(8'h55, g); sel_off();

    // R6 read with auto-increment across wrap
    push_op(3'b011, "R2 read op");
    sel_on(); clr_en();
    byte_x(8'h03, g); byte_x(8'h03, g); byte_x(8'hFF, g);
    check(en_any == 0, "R6 so_en off before data", en_any, 0);
    clr_en(); byte_x(8'h00, g);
    check(g == mem_f(10'h3FF), "R6 read byte 0", g, mem_f(10'h3FF));
    check(en_all == 1, "R6 so_en on during data", en_all, 1);
    byte_x(8'h00, g);
    check(g == mem_f(10'h000), "R6 read byte 1 wrapped", g, mem_f(10'h000));
    byte_x(8'h00, g);
    check(g == mem_f(10'h001), "R6 read byte 2", g, mem_f(10'h001));
    sel_off();
    check(so_en == 0, "R9 so_en after deselect", so_en, 0);

    // R7 read status repeated
    push_op(3'b101, "R2 RDSR op");
    sel_on(); byte_x(8'h05, g);
    byte_x(8'h00, g); check(g == STATUS, "R7 status first", g, STATUS);
    byte_x(8'h00, g); check(g == STATUS, "R7 status repeat", g, STATUS);
    sel_off();

    // R8 invalid opcodes lock the port
    xc = xfer_cnt;
    sel_on(); clr_en(); byte_x(8'hFF, g); byte_x(8'h02, g); byte_x(8'h03, g); sel_off();
    check(en_any == 0, "R8 so_en locked (low bits 111)", en_any, 0);
    sel_on(); clr_en(); byte_x(8'h13, g); byte_x(8'h06, g); byte_x(8'h00, g); sel_off();
    check(en_any == 0, "R8 so_en locked (upper nibble)", en_any, 0);
    check(xfer_cnt == xc, "R8 no xfer_end when locked", xfer_cnt - xc, 0);
    push_op(3'b110, "R8 recovers after reselect");
    sel_on(); byte_x(8'h06, g); sel_off();

    // R9 deselected clocks ignored, partial byte dropped
    byte_x(8'h06, g);
    wait_n(4);
    check(exp_q.size() == 0, "R9 idle clocks ignored", exp_q.size(), 0);
    push_op(3'b010, "R2 write op partial");
    push_wr(1, 10'h010, 8'h77, "R9 full byte kept");
    sel_on(); byte_x(8'h02, g); byte_x(8'h00, g); byte_x(8'h10, g);
    byte_x(8'h77, g); g = '0; bits(8'h99, 7, 3, g); sel_off();

    // R10 hold during write
    push_op(3'b010, "R2 write op hold");
    push_wr(1, 10'h020, 8'hC3, "R10 write across hold");
    sel_on(); byte_x(8'h02, g); byte_x(8'h00, g); byte_x(8'h20, g);
    g = '0; bits(8'hC3, 7, 4, g); hold_pause(); bits(8'hC3, 3, 0, g); sel_off();

    // R10 hold during read
    push_op(3'b011, "R2 read op hold");
    sel_on(); byte_x(8'h03, g); byte_x(8'h00, g); byte_x(8'h40, g);
    g = '0; bits(8'h00, 7, 5, g); hold_pause(); bits(8'h00, 4, 0, g);
    check(g == mem_f(10'h040), "R10 read across hold", g, mem_f(10'h040));
    sel_off();

    wait_n(10);
    check(exp_q.size() == 0, "R2 all expected strobes seen", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule